// File: doc/BRIEF.md
# Real-Time Clock Core with Bus-Side Shadow Copies

This block keeps wall time in a slow oscillator domain and presents it to a fast bus domain. In the oscillator domain a down-counting divider reloads from a programmable value each time it reaches zero. One oscillator period after each reload, a 32-bit tick counter advances by one. With a 32.768 kHz oscillator and a reload of 32767, the counter advances once per second. The core keeps running from its own clock whatever the bus side is doing.

Software never reads the oscillator-domain registers directly. Every oscillator period an update event crosses into the bus domain through a two-flop synchronizer and an edge detector. On the resulting bus cycle, four 16-bit shadow halves (divider low/high, counter low/high) are all latched together, and a sticky "fresh" flag is raised. Reading a low half and then a high half takes two bus accesses, so the two halves may come from different refreshes.

Software changes the reload value and the counter start value only inside a setup window. Closing that window sends both values to the oscillator domain, which restarts the divider from the new reload value. An optional one-bus-cycle tick interrupt pulse is raised whenever a refresh brings in a new counter value.

Top module: `rtc_shadow_core`

## Requirements
- R1: While reset is held and after it is released, the control word, all four shadow halves and the counter start value read zero. The reload register reads 32767 (low half 0x7FFF, high half 0x0000).
- R2: The divider drops by one per oscillator period. When it reaches zero it reloads the programmed value, so counter ticks are spaced (reload+1) oscillator periods apart.
- R3: The counter advances one oscillator period after the divider reloads. A snapshot showing the divider at its full reload value still shows the previous counter value.
- R4: The bus address map is: 0 control, 1 divider low, 2 divider high, 3 counter low, 4 counter high, 5 reload low, 6 reload high, 7 start low, 8 start high. A low half holds bits 15:0 and a high half holds the bits above 15, zero-filled. Other addresses read zero.
- R5: Once per oscillator period all four shadow halves are latched on one bus cycle, and the fresh flag (control bit 2) is set on that cycle. Between refreshes the shadows hold.
- R6: Writing the control word with bit 2 at 0 clears the fresh flag. Writing it with bit 2 at 1 leaves the flag unchanged. If a refresh falls in the same cycle as a clear, the flag stays set.
- R7: Writes to the reload and start registers take effect only while the setup bit (control bit 0) is 1. Otherwise they are ignored.
- R8: Writing the setup bit from 1 to 0 loads the divider with the reload value and the counter with the start value in the oscillator domain.
- R9: When the tick-interrupt enable (control bit 1) is 1, each refresh that changes the shadow counter produces a tick_irq pulse one bus cycle long. With the enable at 0, no pulse is produced.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| osc_clk | input | 1 | Slow oscillator clock, at least 4x slower than bus_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_addr | input | 4 | Register address (see R4) |
| bus_wr | input | 1 | Write strobe, one write per bus cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| tick_irq | output | 1 | One-cycle tick interrupt pulse |

## Verification
Two events can fall on the same bus edge: the hardware refresh that sets the fresh flag, and a software write that clears it. Refreshes arrive at a fixed bus-cycle pitch, so the bench first observes one rise of the flag to learn the refresh phase. It then places a clearing write exactly halfway between refreshes, where the flag must read 0, and another clearing write exactly on a refresh edge, where the flag must still read 1. The tick interrupt and the snapshot sequence are judged against a divider/counter model that the bench computes from the programmed reload and start values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BUS_W  = 16;
  localparam int ADDR_W = 4;

  // bus register map; order is decoded by software
  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_DIV_LO = 4'd1,
    A_DIV_HI = 4'd2,
    A_CNT_LO = 4'd3,
    A_CNT_HI = 4'd4,
    A_RLD_LO = 4'd5,
    A_RLD_HI = 4'd6,
    A_SET_LO = 4'd7,
    A_SET_HI = 4'd8
  } rtc_addr_e;

  // control word bit positions
  localparam int CTL_SETUP   = 0;
  localparam int CTL_TICK_IE = 1;
  localparam int CTL_FRESH   = 2;

  // select one 16-bit half of a zero-extended word
  function automatic logic [BUS_W-1:0] pick_half(input logic [31:0] word,
                                                 input logic        upper);
    return upper ? word[31:16] : word[15:0];
  endfunction

  // replace one 16-bit half of a word
  function automatic logic [31:0] merge_half(input logic [31:0]      word,
                                             input logic             upper,
                                             input logic [BUS_W-1:0] part);
    logic [31:0] r;
    r = word;
    if (upper) r[31:16] = part;
    else       r[15:0]  = part;
    return r;
  endfunction

  // next divider value: count down, reload at zero
  function automatic logic [31:0] div_next(input logic [31:0] cur,
                                           input logic [31:0] reload);
    return (cur == 32'd0) ? reload : cur - 32'd1;
  endfunction

endpackage

// File: rtl/rtc_tgl_sync.sv
// Toggle-to-pulse crossing: STAGES flops of synchronizer plus one history flop.
module rtc_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);

  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= tgl_in;
  end

  for (genvar i = 1; i < LEN; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign pulse = chain[LEN-1] ^ chain[LEN-2];

endmodule

// File: rtl/rtc_osc_core.sv
// Oscillator-domain divider and tick counter.
module rtc_osc_core import rtc_pkg::*; #(
  parameter int DIV_W      = 20,
  parameter int CNT_W      = 32,
  parameter int RELOAD_RST = 32767
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic [DIV_W-1:0] reload_in,
  input  logic [CNT_W-1:0] preset_in,
  output logic [DIV_W-1:0] div_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pend_q,
  output logic [DIV_W-1:0] reload_osc,
  output logic             upd_tgl
);

  logic [DIV_W-1:0] div_d;
  logic             wrap;

  assign wrap  = (div_q == '0);
  assign div_d = DIV_W'(div_next(32'(div_q), 32'(reload_osc)));

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      reload_osc <= DIV_W'(RELOAD_RST);
      upd_tgl    <= 1'b0;
    end else begin
      upd_tgl <= ~upd_tgl;
      if (load_evt) begin
        // restart from freshly transferred values
        reload_osc <= reload_in;
        div_q      <= reload_in;
        cnt_q      <= preset_in;
        pend_q     <= 1'b0;
      end else begin
        div_q  <= div_d;
        pend_q <= wrap;
        if (pend_q) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rtc_bus_regs.sv
// Bus-domain registers: control, setup values, shadows, fresh flag, tick pulse.
module rtc_bus_regs import rtc_pkg::*; #(
  parameter int DIV_W      = 20,
  parameter int CNT_W      = 32,
  parameter int RELOAD_RST = 32767
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              refresh,
  input  logic [DIV_W-1:0]  live_div,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic              tick_irq,
  output logic              load_tgl,
  output logic              cfg_en,
  output logic              irq_en,
  output logic              sync_flag,
  output logic [DIV_W-1:0]  sh_div,
  output logic [DIV_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  sh_cnt,
  output logic [CNT_W-1:0]  preset_q
);

  logic wr_ctrl, wr_rld, wr_set, wr_upper, cnt_moved;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_rld   = bus_wr && cfg_en && ((bus_addr == A_RLD_LO) || (bus_addr == A_RLD_HI));
    wr_set   = bus_wr && cfg_en && ((bus_addr == A_SET_LO) || (bus_addr == A_SET_HI));
    wr_upper = (bus_addr == A_RLD_HI) || (bus_addr == A_SET_HI);
    cnt_moved = live_cnt != sh_cnt;
  end

  // control bits and setup-window exit
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      irq_en   <= 1'b0;
      load_tgl <= 1'b0;
    end else if (wr_ctrl) begin
      cfg_en <= bus_wdata[CTL_SETUP];
      irq_en <= bus_wdata[CTL_TICK_IE];
      if (cfg_en && !bus_wdata[CTL_SETUP]) load_tgl <= ~load_tgl;
    end
  end

  // setup values, writable only inside the window
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= DIV_W'(RELOAD_RST);
      preset_q <= '0;
    end else begin
      if (wr_rld) reload_q <= DIV_W'(merge_half(32'(reload_q), wr_upper, bus_wdata));
      if (wr_set) preset_q <= CNT_W'(merge_half(32'(preset_q), wr_upper, bus_wdata));
    end
  end

  // shadows: all halves captured on the same cycle
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div <= '0;
      sh_cnt <= '0;
    end else if (refresh) begin
      sh_div <= live_div;
      sh_cnt <= live_cnt;
    end
  end

  // fresh flag: hardware set beats software clear
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n)                                  sync_flag <= 1'b0;
    else if (refresh)                            sync_flag <= 1'b1;
    else if (wr_ctrl && !bus_wdata[CTL_FRESH])   sync_flag <= 1'b0;
  end

  // tick pulse when a refresh brings a new counter value
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) tick_irq <= 1'b0;
    else        tick_irq <= refresh && irq_en && cnt_moved;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = BUS_W'({sync_flag, irq_en, cfg_en});
      A_DIV_LO: bus_rdata = pick_half(32'(sh_div), 1'b0);
      A_DIV_HI: bus_rdata = pick_half(32'(sh_div), 1'b1);
      A_CNT_LO: bus_rdata = pick_half(32'(sh_cnt), 1'b0);
      A_CNT_HI: bus_rdata = pick_half(32'(sh_cnt), 1'b1);
      A_RLD_LO: bus_rdata = pick_half(32'(reload_q), 1'b0);
      A_RLD_HI: bus_rdata = pick_half(32'(reload_q), 1'b1);
      A_SET_LO: bus_rdata = pick_half(32'(preset_q), 1'b0);
      A_SET_HI: bus_rdata = pick_half(32'(preset_q), 1'b1);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_shadow_core.sv
// Top: oscillator core, two crossings and the bus register block.
module rtc_shadow_core import rtc_pkg::*; #(
  parameter int DIV_W       = 20,
  parameter int CNT_W       = 32,
  parameter int RELOAD_RST  = 32767,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              tick_irq
);

  // named internal events
  logic             refresh;
  logic             osc_load;
  logic             load_tgl;
  logic             upd_tgl;
  logic             osc_pend;
  logic             cfg_en, irq_en, sync_flag;
  logic [DIV_W-1:0] osc_div, osc_reload, sh_div, reload_q;
  logic [CNT_W-1:0] osc_cnt, sh_cnt, preset_q;

  rtc_osc_core #(
    .DIV_W(DIV_W), .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)
  ) u_osc (
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .load_evt  (osc_load),
    .reload_in (reload_q),
    .preset_in (preset_q),
    .div_q     (osc_div),
    .cnt_q     (osc_cnt),
    .pend_q    (osc_pend),
    .reload_osc(osc_reload),
    .upd_tgl   (upd_tgl)
  );

  // oscillator update event into the bus domain
  rtc_tgl_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
    .clk(bus_clk), .rst_n(rst_n), .tgl_in(upd_tgl), .pulse(refresh)
  );

  // setup-window exit into the oscillator domain
  rtc_tgl_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
    .clk(osc_clk), .rst_n(rst_n), .tgl_in(load_tgl), .pulse(osc_load)
  );

  rtc_bus_regs #(
    .DIV_W(DIV_W), .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)
  ) u_regs (
    .bus_clk  (bus_clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .refresh  (refresh),
    .live_div (osc_div),
    .live_cnt (osc_cnt),
    .tick_irq (tick_irq),
    .load_tgl (load_tgl),
    .cfg_en   (cfg_en),
    .irq_en   (irq_en),
    .sync_flag(sync_flag),
    .sh_div   (sh_div),
    .reload_q (reload_q),
    .sh_cnt   (sh_cnt),
    .preset_q (preset_q)
  );

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk #(
  parameter int DIV_W = 20,
  parameter int CNT_W = 32
) (
  input logic             bus_clk,
  input logic             osc_clk,
  input logic             rst_n,
  input logic             tick_irq,
  input logic             refresh,
  input logic             irq_en,
  input logic             sync_flag,
  input logic             cfg_en,
  input logic [DIV_W-1:0] sh_div,
  input logic [CNT_W-1:0] sh_cnt,
  input logic [DIV_W-1:0] reload_q,
  input logic [CNT_W-1:0] preset_q,
  input logic [DIV_W-1:0] osc_div,
  input logic [CNT_W-1:0] osc_cnt,
  input logic [DIV_W-1:0] osc_reload,
  input logic             osc_load,
  input logic             osc_pend
);

  AST_DIV_STEP: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (osc_div != '0 && !osc_load) |=> osc_div == $past(osc_div) - DIV_W'(1)); // R2

  AST_DIV_RELOAD_OLD_CNT: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (osc_div == '0 && !osc_load) |=> (osc_div == $past(osc_reload)) && (osc_cnt == $past(osc_cnt))); // R3

  AST_CNT_AFTER_RELOAD: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (osc_pend && !osc_load) |=> osc_cnt == $past(osc_cnt) + CNT_W'(1)); // R3

  AST_LOAD_TAKES_SETUP: assert property (@(posedge osc_clk) disable iff (!rst_n)
    osc_load |=> (osc_cnt == $past(preset_q)) && (osc_div == $past(reload_q))); // R8

  AST_FLAG_ON_REFRESH: assert property (@(posedge bus_clk) disable iff (!rst_n)
    refresh |=> sync_flag); // R6

  AST_SHADOW_HOLD: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !refresh |=> ($stable(sh_div) && $stable(sh_cnt))); // R5

  AST_SETUP_GATE: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !cfg_en |=> ($stable(reload_q) && $stable(preset_q))); // R7

  AST_IRQ_ONE_CYCLE: assert property (@(posedge bus_clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq); // R9

  AST_IRQ_GATED: assert property (@(posedge bus_clk) disable iff (!rst_n)
    tick_irq |-> ($past(irq_en) && $past(refresh))); // R9

endmodule

bind rtc_shadow_core rtc_shadow_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .bus_clk   (bus_clk),
  .osc_clk   (osc_clk),
  .rst_n     (rst_n),
  .tick_irq  (tick_irq),
  .refresh   (refresh),
  .irq_en    (irq_en),
  .sync_flag (sync_flag),
  .cfg_en    (cfg_en),
  .sh_div    (sh_div),
  .sh_cnt    (sh_cnt),
  .reload_q  (reload_q),
  .preset_q  (preset_q),
  .osc_div   (osc_div),
  .osc_cnt   (osc_cnt),
  .osc_reload(osc_reload),
  .osc_load  (osc_load),
  .osc_pend  (osc_pend)
);

// File: tb/sim_rtc_shadow_core.sv
module sim_rtc_shadow_core;

  localparam logic [3:0] R_CTRL = 4'd0, R_DLO = 4'd1, R_DHI = 4'd2, R_CLO = 4'd3,
                         R_CHI = 4'd4, R_RLO = 4'd5, R_RHI = 4'd6, R_SLO = 4'd7,
                         R_SHI = 4'd8;
  localparam int RELOAD = 4;
  localparam int RATIO  = 10;   // bus cycles per oscillator period

  logic        clk = 1'b0, osc = 1'b0, rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0, bad = 0, cyc = 0, stray = 0;
  bit mon_on = 1'b0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;                       // 250 MHz
  initial begin #1; forever #20 osc = ~osc; end

  always @(posedge clk) cyc++;

  rtc_shadow_core u0 (
    .bus_clk(clk), .osc_clk(osc), .rst_n(rst_n), .bus_addr(addr),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .tick_irq(irq)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; wr = 1'b0;
    #1 v = rdata;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  // monitor: scoreboard for tick pulses
  initial begin
    int seen = 0, last = 0;
    logic [15:0] e;
    forever begin
      @(negedge clk);
      #1;
      if (irq) begin
        if (mon_on && exp_q.size() > 0) begin
          e = exp_q.pop_front();
          check(rdata == e, "R9 tick value (R8 load, R4 low half)", rdata, e);
          if (seen >= 2)
            check(cyc - last == (RELOAD + 1) * RATIO, "R2 tick spacing",
                  cyc - last, (RELOAD + 1) * RATIO);
          last = cyc;
          seen++;
        end else begin
          stray++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, p_prev, c_prev, p, c, ep, ec;
    int n;

    // R1 reset state
    rd(R_CTRL, v); check(v == 16'h0, "R1 ctrl", v, 0);
    rd(R_DLO, v);  check(v == 16'h0, "R1 div lo", v, 0);
    rd(R_DHI, v);  check(v == 16'h0, "R1 div hi", v, 0);
    rd(R_CLO, v);  check(v == 16'h0, "R1 cnt lo", v, 0);
    rd(R_CHI, v);  check(v == 16'h0, "R1 cnt hi", v, 0);
    rd(R_RLO, v);  check(v == 16'h7FFF, "R1 reload lo", v, 16'h7FFF);
    rd(R_SLO, v);  check(v == 16'h0, "R1 start lo", v, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(R_CTRL, v); check(v == 16'h0, "R1 ctrl after release", v, 0);
    repeat (60) @(negedge clk);

    // R7 write outside setup ignored
    wr_reg(R_RLO, 16'd4);
    rd(R_RLO, v); check(v == 16'h7FFF, "R7 ignored reload write", v, 16'h7FFF);

    // R7/R8 program values in setup window
    wr_reg(R_CTRL, 16'h1);
    wr_reg(R_RLO, 16'(RELOAD));
    wr_reg(R_RHI, 16'h0);
    wr_reg(R_SLO, 16'hFFFE);
    wr_reg(R_SHI, 16'h0);
    rd(R_RLO, v); check(v == 16'(RELOAD), "R7 reload write", v, RELOAD);
    rd(R_SLO, v); check(v == 16'hFFFE, "R7 start write", v, 16'hFFFE);
    exp_q.push_back(16'hFFFE);
    exp_q.push_back(16'hFFFF);
    exp_q.push_back(16'h0000);
    exp_q.push_back(16'h0001);
    mon_on = 1'b1;
    wr_reg(R_CTRL, 16'h2);          // leave setup, tick interrupt on
    @(negedge clk); addr = R_CLO;
    n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, "R9 all ticks seen", exp_q.size(), 0);
    mon_on = 1'b0;
    rd(R_CHI, v); check(v == 16'h0001, "R4 counter high half carry", v, 1);
    wr_reg(R_CTRL, 16'h0);

    // R2/R3 snapshot sequence, one sample per refresh
    for (int k = 0; k < 13; k++) begin
      n = 0;
      do begin rd(R_CTRL, v); n++; end while (!v[2] && n < 100);
      if (n >= 100) check(1'b0, "R5 refresh flag timeout", 0, 1);
      wr_reg(R_CTRL, 16'h0);
      rd(R_DLO, p);
      rd(R_CLO, c);
      if (k > 0) begin
        ep = (p_prev == 16'd0) ? 16'(RELOAD) : p_prev - 16'd1;
        ec = (p_prev == 16'(RELOAD)) ? c_prev + 16'd1 : c_prev;
        check(p == ep, "R2 divider step", p, ep);
        check(c == ec, "R3 counter lags reload", c, ec);
      end
      p_prev = p; c_prev = c;
    end

    // R6 flag clear versus refresh in the same cycle
    do begin wr_reg(R_CTRL, 16'h0); rd(R_CTRL, v); end while (v[2]);
    n = 0;
    do begin rd(R_CTRL, v); n++; end while (!v[2] && n < 100);   // seen at P+0.5
    repeat (3) @(negedge clk);
    wr_reg(R_CTRL, 16'h0);                                         // edge P+5
    rd(R_CTRL, v); check(v[2] == 1'b0, "R6 clear between refreshes", v, 0);
    wr_reg(R_CTRL, 16'h4);                                         // edge P+7
    rd(R_CTRL, v); check(v[2] == 1'b0, "R6 writing one has no effect", v, 0);
    repeat (11) @(negedge clk);
    wr_reg(R_CTRL, 16'h0);                                         // edge P+20, refresh
    rd(R_CTRL, v); check(v[2] == 1'b1, "R6 refresh wins over clear", v, 4);

    // R9 no pulse while disabled
    repeat (150) @(negedge clk);
    check(stray == 0, "R9 no pulse when disabled", stray, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule